// File: doc/BRIEF.md
# Way-Partitioned Victim Selector

This block picks the way to evict when a line is filled into a 16-way cache shared by two cores. Every line carries one owner bit naming the core that filled it. On a miss the block counts how many valid lines in the indexed set belong to the requesting core and compares that count with the core's quota of ways. Below quota, the requester takes a line from the other core. At or above quota, it gives up one of its own lines. Either way, the line chosen is the least recently used one in the group.

Partitions move toward a new target only as misses occur, and no line is ever flushed. Empty ways are used before any partition rule applies. The block also returns the set's owner vector with the victim bit rewritten to the requester, so the fill can write it back. The two quotas are loaded together and are kept only when they add up to the way count.

Top module: `way_part_victim`

## Requirements
- R1: After reset, `vic_valid` is 0 and both quotas are WAYS/2 (8 each).
- R2: If any way in the set is invalid (`way_valid` bit = 0), the victim is the lowest-index invalid way, whatever the owners and quotas are.
- R3: When every way is valid and the requester owns fewer lines than its quota, the victim is the way with the largest rank (rank WAYS-1 = least recent, rank 0 = most recent) among lines owned by the other core.
- R4: When every way is valid and the requester owns at least its quota, the victim is the largest-rank way among the requester's own lines.
- R5: If the preferred owner has no lines in the set, the victim is the largest-rank way of the whole set.
- R6: A quota load (`tgt_we`=1) is kept only when `tgt_core0 + tgt_core1` equals WAYS. Otherwise both quotas keep their previous values.
- R7: `vic_owner_next` equals `way_owner` with only the victim bit replaced by the requesting core id (0 = core 0, 1 = core 1).
- R8: `vic_valid`, `vic_way` and `vic_owner_next` are registered and appear one cycle after `miss_valid`. A miss in the same cycle as a quota load uses the old quotas.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tgt_we | input | 1 | Load new quotas |
| tgt_core0 | input | $clog2(WAYS+1) | Requested ways for core 0 |
| tgt_core1 | input | $clog2(WAYS+1) | Requested ways for core 1 |
| miss_valid | input | 1 | A miss needs a victim this cycle |
| miss_core | input | 1 | Requesting core id |
| way_valid | input | WAYS | Valid bit of each way in the set |
| way_owner | input | WAYS | Owner bit of each way in the set |
| way_rank | input | WAYS*$clog2(WAYS) | Recency rank per way, way i in bits [i*RW +: RW] |
| vic_valid | output | 1 | Victim result valid |
| vic_way | output | $clog2(WAYS) | Chosen victim way |
| vic_owner_next | output | WAYS | Owner vector after the fill |

## Verification
The bench covers sets with invalid ways scattered among valid ones. A design that picks the highest invalid way, or applies the quota rule to a set that is not full, evicts a live line. It sets the requester's count to exactly its quota, where an off-by-one comparison steals from the other core instead of recycling the requester's own line. With quotas of 0 and 16 the preferred owner has no lines in the set, so a design without the fallback returns way 0 instead of the set's LRU way. Quota loads whose sum is wrong must leave the partition as it was, and a miss issued together with a load must still use the old quota.

// File: rtl/way_part_victim.sv
module way_part_victim #(
  parameter int WAYS = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              tgt_we,
  input  logic [$clog2(WAYS+1)-1:0]         tgt_core0,
  input  logic [$clog2(WAYS+1)-1:0]         tgt_core1,
  input  logic                              miss_valid,
  input  logic                              miss_core,
  input  logic [WAYS-1:0]                   way_valid,
  input  logic [WAYS-1:0]                   way_owner,
  input  logic [WAYS*$clog2(WAYS)-1:0]      way_rank,
  output logic                              vic_valid,
  output logic [$clog2(WAYS)-1:0]           vic_way,
  output logic [WAYS-1:0]                   vic_owner_next
);
  localparam int IW = $clog2(WAYS);
  localparam int CW = $clog2(WAYS+1);

  logic [CW-1:0] quota0, quota1, quota_req, own_cnt;
  logic          inv_hit, pref, pref_found;
  logic [IW-1:0] inv_idx, pref_idx, all_idx, pick;
  logic [IW-1:0] pref_rank, all_rank, r;
  logic [CW:0]   tgt_sum;

  assign tgt_sum   = {1'b0, tgt_core0} + {1'b0, tgt_core1};
  assign quota_req = miss_core ? quota1 : quota0;
  assign pref      = (own_cnt < quota_req) ? ~miss_core : miss_core;

  always_comb begin
    inv_hit = 1'b0;
    inv_idx = '0;
    own_cnt = '0;
    for (int i = WAYS-1; i >= 0; i--) begin
      if (!way_valid[i]) begin
        inv_hit = 1'b1;
        inv_idx = IW'(i);
      end
    end
    for (int i = 0; i < WAYS; i++)
      if (way_valid[i] && way_owner[i] == miss_core) own_cnt = own_cnt + 1'b1;
  end

  always_comb begin
    pref_found = 1'b0;
    pref_idx   = '0;
    pref_rank  = '0;
    all_idx    = '0;
    all_rank   = '0;
    r          = '0;
    for (int i = 0; i < WAYS; i++) begin
      r = way_rank[i*IW +: IW];
      if (way_owner[i] == pref && (!pref_found || r > pref_rank)) begin
        pref_found = 1'b1;
        pref_idx   = IW'(i);
        pref_rank  = r;
      end
      if (i == 0 || r > all_rank) begin
        all_idx  = IW'(i);
        all_rank = r;
      end
    end
  end

  assign pick = inv_hit ? inv_idx : (pref_found ? pref_idx : all_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quota0         <= CW'(WAYS/2);
      quota1         <= CW'(WAYS - WAYS/2);
      vic_valid      <= 1'b0;
      vic_way        <= '0;
      vic_owner_next <= '0;
    end else begin
      if (tgt_we && tgt_sum == (CW+1)'(WAYS)) begin
        quota0 <= tgt_core0;
        quota1 <= tgt_core1;
      end
      vic_valid <= miss_valid;
      if (miss_valid) begin
        vic_way        <= pick;
        vic_owner_next <= (way_owner & ~(WAYS'(1) << pick)) |
                          (WAYS'(miss_core) << pick);
      end
    end
  end

  AST_QUOTA_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, quota0} + {1'b0, quota1}) == (CW+1)'(WAYS)); // R6
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> vic_valid == $past(miss_valid)); // R8
  AST_FILL_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    vic_valid && $past(rst_n) |-> vic_owner_next[vic_way] == $past(miss_core)); // R7
  AST_OTHERS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    vic_valid && $past(rst_n) |->
      ((vic_owner_next ^ $past(way_owner)) & ~(WAYS'(1) << vic_way)) == '0); // R7
  AST_INVALID_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    vic_valid && $past(rst_n) && !$past(&way_valid) |->
      (($past(way_valid) >> vic_way) & WAYS'(1)) == '0); // R2
endmodule

// File: tb/way_part_victim_tb.sv
module way_part_victim_tb;
  localparam int WAYS = 16;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tgt_we = 1'b0;
  logic [4:0]  tgt_core0 = '0, tgt_core1 = '0;
  logic        miss_valid = 1'b0, miss_core = 1'b0;
  logic [15:0] way_valid = '1, way_owner = '0;
  logic [63:0] way_rank = '0;
  logic        vic_valid;
  logic [3:0]  vic_way;
  logic [15:0] vic_owner_next;

  int n_chk = 0, n_bad = 0;
  int q0 = 8, q1 = 8;

  always #5 clk = ~clk;

  way_part_victim #(.WAYS(WAYS)) u_dut (
    .clk, .rst_n, .tgt_we, .tgt_core0, .tgt_core1, .miss_valid, .miss_core,
    .way_valid, .way_owner, .way_rank, .vic_valid, .vic_way, .vic_owner_next);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rank_of(int i, int rot);
    return (i + rot) % 16;
  endfunction

  function automatic int model(logic [15:0] v, logic [15:0] o, int rot,
                               logic c, int a0, int a1);
    int cnt = 0, best = -1, best_r = -1, all = 0, all_r = -1;
    logic p;
    for (int i = 0; i < 16; i++) if (!v[i]) return i;
    for (int i = 0; i < 16; i++) if (o[i] == c) cnt++;
    p = (cnt < (c ? a1 : a0)) ? ~c : c;
    for (int i = 0; i < 16; i++) begin
      if (o[i] == p && rank_of(i, rot) > best_r) begin best = i; best_r = rank_of(i, rot); end
      if (rank_of(i, rot) > all_r) begin all = i; all_r = rank_of(i, rot); end
    end
    return (best >= 0) ? best : all;
  endfunction

  task automatic do_miss(input string req, input logic c, input logic [15:0] v,
                         input logic [15:0] o, input int rot, input bit with_load,
                         input int l0, input int l1);
    int ew;
    logic [15:0] eo;
    ew = model(v, o, rot, c, q0, q1);
    eo = o;
    eo[ew] = c;
    @(negedge clk);
    miss_core = c; way_valid = v; way_owner = o;
    for (int i = 0; i < 16; i++) way_rank[i*4 +: 4] = 4'(rank_of(i, rot));
    miss_valid = 1'b1;
    if (with_load) begin tgt_we = 1'b1; tgt_core0 = 5'(l0); tgt_core1 = 5'(l1); end
    @(negedge clk);
    miss_valid = 1'b0; tgt_we = 1'b0;
    if (with_load && l0 + l1 == 16) begin q0 = l0; q1 = l1; end
    chk({req, " valid"}, int'(vic_valid), 1);
    chk({req, " way"}, int'(vic_way), ew);
    chk({req, " owners"}, int'(vic_owner_next), int'(eo));
  endtask

  task automatic load(input int l0, input int l1);
    @(negedge clk);
    tgt_we = 1'b1; tgt_core0 = 5'(l0); tgt_core1 = 5'(l1);
    @(negedge clk);
    tgt_we = 1'b0;
    if (l0 + l1 == 16) begin q0 = l0; q1 = l1; end
  endtask

  task automatic t_reset;
    chk("R1 reset valid", int'(vic_valid), 0);
    do_miss("R1 default quota", 1'b0, 16'hFFFF, 16'hFF80, 3, 0, 0, 0);
  endtask

  task automatic t_invalid;
    do_miss("R2 lowest invalid", 1'b1, 16'hFFF5, 16'h0000, 0, 0, 0, 0);
    chk("R2 explicit way", int'(vic_way), 1);
    do_miss("R2 top invalid", 1'b0, 16'h7FFF, 16'hFFFF, 7, 0, 0, 0);
  endtask

  task automatic t_under;
    do_miss("R3 steal from other", 1'b0, 16'hFFFF, 16'hFFF0, 5, 0, 0, 0);
    do_miss("R3 core1 under", 1'b1, 16'hFFFF, 16'h0007, 11, 0, 0, 0);
  endtask

  task automatic t_over;
    do_miss("R4 at quota", 1'b0, 16'hFFFF, 16'hFF00, 9, 0, 0, 0);
    do_miss("R4 over quota", 1'b1, 16'hFFFF, 16'hFFF0, 2, 0, 0, 0);
  endtask

  task automatic t_fallback;
    load(0, 16);
    do_miss("R5 fallback lru", 1'b0, 16'hFFFF, 16'hFFFF, 6, 0, 0, 0);
    chk("R5 explicit way", int'(vic_way), 9);
  endtask

  task automatic t_reject;
    load(12, 4);
    load(10, 5);
    do_miss("R6 bad sum ignored", 1'b0, 16'hFFFF, 16'hF800, 4, 0, 0, 0);
    chk("R6 explicit steal", int'(u_dut.vic_owner_next[vic_way] == 1'b0 && vic_way >= 11), 1);
  endtask

  task automatic t_same_cycle;
    load(8, 8);
    do_miss("R8 old quota used", 1'b0, 16'hFFFF, 16'hFF00, 1, 1, 14, 2);
    do_miss("R7 R8 new quota", 1'b0, 16'hFFFF, 16'hFF00, 1, 0, 0, 0);
    @(negedge clk);
    chk("R8 valid drops", int'(vic_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_invalid;
    t_under;
    t_over;
    t_fallback;
    t_reject;
    t_same_cycle;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule